// File: doc/BRIEF.md
# Doorbell Interrupt Register Block

A small register file on a 32-bit register bus. It holds two outbound descriptor words, a control word, an interrupt status word and a software-interrupt word. It drives one level interrupt line. That line is not derived from status and mask bits. It is a sticky flag that particular register writes set and others clear.

A producer rings the doorbell in one of two ways. It can write descriptor B with the ring bit set, or it can write the software-interrupt set offset. The consumer acknowledges through the control word, the status word or the software-interrupt clear offset. Every access is a full 32-bit word with little-endian byte order. A write takes effect on the clock edge that accepts it. A read returns its data one cycle later, together with a one-cycle response pulse.

Top module: `doorbell_irq_regs`

## Requirements
- R1: Reset (rst_ni low) clears all five registers and the interrupt line to 0, and holds rsp_valid_o low.
- R2: Descriptor A sits at offset 0x28 and descriptor B at offset 0x2C. Both store and read back all 32 written bits.
- R3: A write to descriptor B with bit 29 set drives irq_o high from the accepting edge onward. The full written value is still stored.
- R4: A write to control (offset 0x4C) stores the full value. If bit 16 of the data is set, the write drives irq_o low. A read of control returns the stored value with bit 17 forced to 1.
- R5: A write to interrupt status (offset 0x50) replaces its contents. If bit 16 or bit 29 of the data is set, the write drives irq_o low.
- R6: A write to offset 0x1F0 ORs the data into the software-interrupt register. It always drives irq_o high, even when the data is zero.
- R7: A write to offset 0x1F4 clears the software-interrupt bits that are 1 in the data. It always drives irq_o low, even when the data is zero.
- R8: A read of either 0x1F0 or 0x1F4 returns the current software-interrupt register.
- R9: A read of any other offset returns 0, including an unaligned address. A write to any other offset changes no register and leaves irq_o unchanged.
- R10: A mapped write that carries no set or clear condition leaves irq_o unchanged. This covers a descriptor A write, a descriptor B write without bit 29, a control write without bit 16, and a status write with neither bit 16 nor bit 29.
- R11: A read accepted on edge N raises rsp_valid_o for exactly the cycle after edge N, with the data on rsp_rdata_o. A write produces no response pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present; accepted on every edge |
| req_write_i | input | 1 | 1 for a write, 0 for a read |
| req_addr_i | input | ADDR_W (12) | Byte offset of the register |
| req_wdata_i | input | DATA_W (32) | Write data |
| rsp_valid_o | output | 1 | One-cycle read response pulse |
| rsp_rdata_o | output | DATA_W (32) | Read data, valid while rsp_valid_o is high |
| irq_o | output | 1 | Sticky doorbell interrupt line |

## Verification
The interrupt flag has one bit of hidden state, and every write event can change it. A wrong set or clear decision therefore appears on irq_o at the very next sample after the accepting edge. After that it persists until a later event moves it, so the bench samples irq_o after every write. A corrupted register word only appears when that word is read, one cycle after the read request. For that reason each scenario reads back every word it touched. The unmapped-offset scenario also reads back the words it did not touch.

// File: rtl/dbirq_pkg.sv
package dbirq_pkg;
  localparam int DATA_W    = 32;
  localparam int NUM_SLOTS = 6;
  localparam int NUM_STORE = 4;  // plain read/write words occupy slots 0..3

  localparam int SLOT_DESC_A = 0;
  localparam int SLOT_DESC_B = 1;
  localparam int SLOT_CTRL   = 2;
  localparam int SLOT_STAT   = 3;
  localparam int SLOT_SW_SET = 4;
  localparam int SLOT_SW_CLR = 5;

  localparam int RING_BIT      = 29;  // descriptor B: raise line
  localparam int CTRL_ACK_BIT  = 16;  // control: drop line
  localparam int CTRL_ONE_BIT  = 17;  // control: always reads 1
  localparam int STAT_ACK_LO   = 16;
  localparam int STAT_ACK_HI   = 29;

  function automatic int slot_offset(input int idx);
    case (idx)
      SLOT_DESC_A: return 'h028;
      SLOT_DESC_B: return 'h02C;
      SLOT_CTRL:   return 'h04C;
      SLOT_STAT:   return 'h050;
      SLOT_SW_SET: return 'h1F0;
      default:     return 'h1F4;
    endcase
  endfunction
endpackage

// File: rtl/dbirq_decode.sv
module dbirq_decode
  import dbirq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                 req_valid_i,
  input  logic                 req_write_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  output logic [NUM_SLOTS-1:0] wr_hit_o,
  output logic [NUM_SLOTS-1:0] rd_hit_o
);
  logic [NUM_SLOTS-1:0] hit;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    localparam logic [ADDR_W-1:0] OFF = ADDR_W'(slot_offset(i));
    assign hit[i] = (req_addr_i == OFF);
  end

  assign wr_hit_o = hit & {NUM_SLOTS{req_valid_i &  req_write_i}};
  assign rd_hit_o = hit & {NUM_SLOTS{req_valid_i & ~req_write_i}};
endmodule

// File: rtl/dbirq_store.sv
module dbirq_store
  import dbirq_pkg::*;
(
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_SLOTS-1:0]              wr_hit_i,
  input  logic [DATA_W-1:0]                 wdata_i,
  output logic [NUM_STORE-1:0][DATA_W-1:0]  word_o,
  output logic [DATA_W-1:0]                 swirq_o
);
  for (genvar i = 0; i < NUM_STORE; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          word_o[i] <= '0;
      else if (wr_hit_i[i]) word_o[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     swirq_o <= '0;
    else if (wr_hit_i[SLOT_SW_SET])  swirq_o <= swirq_o | wdata_i;
    else if (wr_hit_i[SLOT_SW_CLR])  swirq_o <= swirq_o & ~wdata_i;
  end
endmodule

// File: rtl/dbirq_flag.sv
module dbirq_flag
  import dbirq_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SLOTS-1:0] wr_hit_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic                 set_ev_o,
  output logic                 clr_ev_o,
  output logic                 irq_o
);
  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  assign set_ev_o = (wr_hit_i[SLOT_DESC_B] & wdata_i[RING_BIT])
                  |  wr_hit_i[SLOT_SW_SET];
  assign clr_ev_o = (wr_hit_i[SLOT_CTRL] & wdata_i[CTRL_ACK_BIT])
                  | (wr_hit_i[SLOT_STAT] & (wdata_i[STAT_ACK_LO] | wdata_i[STAT_ACK_HI]))
                  |  wr_hit_i[SLOT_SW_CLR];

  // clear has priority should both ever coincide
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       irq_o <= 1'b0;
    else if (clr_ev_o) irq_o <= 1'b0;
    else if (set_ev_o) irq_o <= 1'b1;
  end
endmodule

// File: rtl/dbirq_resp.sv
module dbirq_resp
  import dbirq_pkg::*;
(
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              rd_req_i,
  input  logic [NUM_SLOTS-1:0]              rd_hit_i,
  input  logic [NUM_STORE-1:0][DATA_W-1:0]  word_i,
  input  logic [DATA_W-1:0]                 swirq_i,
  output logic                              rsp_valid_o,
  output logic [DATA_W-1:0]                 rsp_rdata_o
);
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_STORE; i++)
      if (rd_hit_i[i]) rd_next = word_i[i];
    if (rd_hit_i[SLOT_CTRL]) rd_next[CTRL_ONE_BIT] = 1'b1;
    if (rd_hit_i[SLOT_SW_SET] | rd_hit_i[SLOT_SW_CLR]) rd_next = swirq_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= rd_req_i;
      if (rd_req_i) rsp_rdata_o <= rd_next;
    end
  end
endmodule

// File: rtl/doorbell_irq_regs.sv
module doorbell_irq_regs
  import dbirq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              irq_o
);
  logic [NUM_SLOTS-1:0]             wr_hit, rd_hit;
  logic [NUM_STORE-1:0][DATA_W-1:0] word;
  logic [DATA_W-1:0]                swirq;
  logic                             set_ev, clr_ev;

  dbirq_decode #(.ADDR_W(ADDR_W)) u_decode (
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .wr_hit_o    (wr_hit),
    .rd_hit_o    (rd_hit)
  );

  dbirq_store u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_hit_i (wr_hit),
    .wdata_i  (req_wdata_i),
    .word_o   (word),
    .swirq_o  (swirq)
  );

  dbirq_flag u_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_hit_i (wr_hit),
    .wdata_i  (req_wdata_i),
    .set_ev_o (set_ev),
    .clr_ev_o (clr_ev),
    .irq_o    (irq_o)
  );

  dbirq_resp u_resp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_req_i    (req_valid_i & ~req_write_i),
    .rd_hit_i    (rd_hit),
    .word_i      (word),
    .swirq_i     (swirq),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o)
  );
endmodule

// File: rtl/doorbell_irq_regs_chk.sv
module doorbell_irq_regs_chk
  import dbirq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [DATA_W-1:0] req_wdata_i,
  input logic              rsp_valid_o,
  input logic [DATA_W-1:0] rsp_rdata_o,
  input logic              irq_o,
  input logic              set_ev,
  input logic              clr_ev
);
  logic wr, rd, mapped;
  assign wr = req_valid_i &  req_write_i;
  assign rd = req_valid_i & ~req_write_i;
  assign mapped = (req_addr_i == ADDR_W'('h028)) || (req_addr_i == ADDR_W'('h02C)) ||
                  (req_addr_i == ADDR_W'('h04C)) || (req_addr_i == ADDR_W'('h050)) ||
                  (req_addr_i == ADDR_W'('h1F0)) || (req_addr_i == ADDR_W'('h1F4));

  assert_sw_set_raises_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && req_addr_i == ADDR_W'('h1F0)) |=> irq_o);

  assert_sw_clr_drops_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && req_addr_i == ADDR_W'('h1F4)) |=> !irq_o);

  assert_ring_raises_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && req_addr_i == ADDR_W'('h02C) && req_wdata_i[29]) |=> irq_o);

  assert_rise_has_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(wr && (req_addr_i == ADDR_W'('h1F0) ||
                                  (req_addr_i == ADDR_W'('h02C) && req_wdata_i[29]))));

  assert_unmapped_write_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && !mapped) |=> $stable(irq_o));

  assert_unmapped_read_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && !mapped) |=> (rsp_rdata_o == '0));

  assert_ctrl_bit_one_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && req_addr_i == ADDR_W'('h04C)) |=> rsp_rdata_o[17]);

  assert_read_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> rsp_valid_o);

  assert_no_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> !rsp_valid_o);

  assert_set_clr_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_ev && clr_ev));
endmodule

bind doorbell_irq_regs doorbell_irq_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_addr_i  (req_addr_i),
  .req_wdata_i (req_wdata_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_rdata_o (rsp_rdata_o),
  .irq_o       (irq_o),
  .set_ev      (set_ev),
  .clr_ev      (clr_ev)
);

// File: tb/doorbell_irq_regs_test.sv
module doorbell_irq_regs_test;
  localparam int ADDR_W = 12;
  localparam logic [11:0] A_DA = 12'h028, A_DB = 12'h02C, A_CT = 12'h04C,
                          A_ST = 12'h050, A_SS = 12'h1F0, A_SC = 12'h1F4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, irq;
  logic [31:0] rsp_rdata;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  doorbell_irq_regs #(.ADDR_W(ADDR_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid),
    .rsp_rdata_o(rsp_rdata), .irq_o(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    chk("R11 no pulse on write", {31'b0, rsp_valid}, 32'd0);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk("R11 read pulse", {31'b0, rsp_valid}, 32'd1);
    d = rsp_rdata;
    @(negedge clk);
    chk("R11 pulse one cycle", {31'b0, rsp_valid}, 32'd0);
  endtask

  task automatic rdchk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic irqchk(input string req, input logic exp);
    chk(req, {31'b0, irq}, {31'b0, exp});
  endtask

  task automatic t_reset;
    irqchk("R1 irq after reset", 1'b0);
    chk("R1 rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
    rdchk("R1 desc A zero", A_DA, 0);
    rdchk("R1 desc B zero", A_DB, 0);
    rdchk("R1 ctrl zero but bit17", A_CT, 32'h0002_0000);
    rdchk("R1 status zero", A_ST, 0);
    rdchk("R1 swirq zero", A_SS, 0);
  endtask

  task automatic t_desc;
    wr(A_DA, 32'hA5A5_1234);
    irqchk("R10 desc A leaves irq", 1'b0);
    rdchk("R2 desc A readback", A_DA, 32'hA5A5_1234);
    wr(A_DB, 32'hDFFF_FFFF);
    irqchk("R10 desc B w/o bit29 leaves irq", 1'b0);
    rdchk("R2 desc B readback", A_DB, 32'hDFFF_FFFF);
    wr(A_DB, 32'h2000_0001);
    irqchk("R3 ring raises irq", 1'b1);
    rdchk("R3 desc B stored", A_DB, 32'h2000_0001);
  endtask

  task automatic t_ctrl;
    wr(A_CT, 32'h0000_0003);
    irqchk("R10 ctrl w/o bit16 leaves irq", 1'b1);
    rdchk("R4 ctrl read forces bit17", A_CT, 32'h0002_0003);
    wr(A_CT, 32'h0001_0000);
    irqchk("R4 ctrl bit16 drops irq", 1'b0);
    rdchk("R4 ctrl stored", A_CT, 32'h0003_0000);
  endtask

  task automatic t_stat;
    wr(A_SS, 0);
    irqchk("R6 zero set raises", 1'b1);
    wr(A_ST, 32'hDFFE_1234);
    irqchk("R10 status w/o ack leaves irq", 1'b1);
    rdchk("R5 status replaced", A_ST, 32'hDFFE_1234);
    wr(A_ST, 32'h2000_0000);
    irqchk("R5 status bit29 drops", 1'b0);
    rdchk("R5 status replaced again", A_ST, 32'h2000_0000);
    wr(A_SS, 0);
    wr(A_ST, 32'h0001_0000);
    irqchk("R5 status bit16 drops", 1'b0);
  endtask

  task automatic t_swirq;
    wr(A_SS, 32'h0000_000F);
    irqchk("R6 set raises", 1'b1);
    rdchk("R8 read via set", A_SS, 32'h0000_000F);
    wr(A_SS, 32'h0000_00F0);
    rdchk("R6 set ORs", A_SS, 32'h0000_00FF);
    wr(A_SC, 32'h0000_003C);
    irqchk("R7 clear drops", 1'b0);
    rdchk("R8 read via clear", A_SC, 32'h0000_00C3);
    wr(A_SS, 0);
    irqchk("R6 zero set raises", 1'b1);
    wr(A_SC, 0);
    irqchk("R7 zero clear drops", 1'b0);
    rdchk("R7 zero clear keeps bits", A_SS, 32'h0000_00C3);
  endtask

  task automatic t_unmapped;
    wr(A_SS, 0);
    wr(12'h030, 32'hFFFF_FFFF);
    irqchk("R9 unmapped write keeps irq high", 1'b1);
    wr(A_SC, 0);
    wr(12'h2AC, 32'h2000_0000);
    irqchk("R9 unmapped write keeps irq low", 1'b0);
    wr(12'h02D, 32'h2000_0000);
    irqchk("R9 unaligned write keeps irq low", 1'b0);
    rdchk("R9 unmapped read zero", 12'h030, 0);
    rdchk("R9 unaligned read zero", 12'h02A, 0);
    rdchk("R9 desc A untouched", A_DA, 32'hA5A5_1234);
    rdchk("R9 desc B untouched", A_DB, 32'h2000_0001);
    rdchk("R9 status untouched", A_ST, 32'h0001_0000);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = A_DA;
    @(negedge clk);
    req_addr = A_SC;
    chk("R11 first of pair", rsp_rdata, 32'hA5A5_1234);
    @(negedge clk);
    req_valid = 0;
    chk("R11 second pulse", {31'b0, rsp_valid}, 32'd1);
    chk("R11 second of pair", rsp_rdata, 32'h0000_00C3);
    @(negedge clk);
    chk("R11 pulse ends", {31'b0, rsp_valid}, 32'd0);
  endtask

  task automatic t_midrun_reset;
    wr(A_SS, 32'h55);
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    irqchk("R1 reset drops irq", 1'b0);
    rst_n = 1;
    rdchk("R1 swirq cleared", A_SC, 0);
    rdchk("R1 desc A cleared", A_DA, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_desc();
    t_ctrl();
    t_stat();
    t_swirq();
    t_unmapped();
    t_back_to_back();
    t_midrun_reset();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule